// File: doc/BRIEF.md
# Serial Display Byte Transmitter

This block moves bytes from a host to a small character display controller over a four-wire serial link. The four wires are an active-low chip select, a register-select line, a serial clock and a serial data line. The host asks for one of two transfer kinds with a single-cycle `start` strobe. A command transfer sends exactly one byte to the instruction register. A data transfer sends a burst of one or more bytes to the data register.

In both kinds the bytes are pulled one at a time from a byte-wide valid/ready input. The block shifts each byte out most significant bit first and paces the serial clock with a parameterised divider. While a transfer runs it holds `busy`, and it pulses `done` once all four lines are back at their idle level.

The serial clock idles high. It is driven low when a transfer opens. The display samples the data line on every rising edge, so the data line only changes while the clock is low. The display takes the register-select level at the eighth rising edge of each byte, and the block holds that level for the whole transfer.

Top module: `serdisp_tx`

## Requirements
- R1: After reset, `dsp_csn`, `dsp_rs`, `dsp_sck` and `dsp_sdo` are all 1, and `busy`, `done` and `din_ready` are 0.
- R2: A `start` with `is_data`=0 opens a command transfer. `byte_count` is ignored, exactly one byte is taken through the handshake, and `dsp_rs` is 0 for the whole transfer.
- R3: A `start` with `is_data`=1 and `byte_count`=N (N ≥ 1) sends N bytes with `dsp_rs`=1. Each byte is taken on a cycle where `din_valid` and `din_ready` are both 1.
- R4: Each byte produces exactly eight rising edges of `dsp_sck`. The `dsp_sdo` levels at those edges are the byte's bits from bit 7 down to bit 0.
- R5: `dsp_sdo` never changes while `dsp_sck` stays high with `dsp_csn` low.
- R6: Every high phase of `dsp_sck` inside a transfer lasts exactly CLK_DIV clock cycles. Every low phase before a rising edge lasts at least CLK_DIV cycles.
- R7: On the cycle after an accepted `start`, `dsp_csn`=0, `dsp_sck`=0, `dsp_sdo`=1 and `din_ready`=1, before the first byte is supplied.
- R8: `dsp_csn` goes low once per transfer and stays low between the bytes of a burst.
- R9: `dsp_rs` does not change while `dsp_csn` is low.
- R10: At the end of the last byte, all four lines go to 1 on the same clock edge. `done` is 1 for exactly that one cycle, and `busy` is 0 from that cycle on.
- R11: A data request with `byte_count`=0 is ignored: no line moves, and `busy` and `din_ready` stay 0.
- R12: A `start` that arrives while `busy` is 1 is ignored. The running transfer completes unchanged and produces one `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle transfer request |
| is_data | input | 1 | 1 for a data burst, 0 for a single command byte |
| byte_count | input | CNT_W | Burst length for data requests |
| din | input | BYTE_W | Byte offered by the host |
| din_valid | input | 1 | `din` holds a byte |
| din_ready | output | 1 | Block takes `din` on this cycle if valid |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse when the lines have returned to idle |
| dsp_csn | output | 1 | Chip select to the display, active low |
| dsp_rs | output | 1 | Register select: 0 instruction, 1 data |
| dsp_sck | output | 1 | Serial clock, idles high |
| dsp_sdo | output | 1 | Serial data, sampled on rising `dsp_sck` |

## Verification
A bad state register makes itself seen on the lines within one half-period of the serial clock. The likely signs are a high phase whose length differs from CLK_DIV, a data change while the clock is high, or chip select rising in the middle of a burst. A wrong byte counter shows up only at the end of a burst. There the lines either close one byte early or stall in a fetch with `din_ready` held high, so each burst is checked for its exact byte count and for a single `done`. A wrong bit counter corrupts the byte that the bench rebuilds from the rising edges, and it does so within that same byte.

// File: rtl/serdisp_pkg.sv
// Shared types for the serial display transmitter.
package serdisp_pkg;
    typedef enum logic [1:0] {
        SD_IDLE  = 2'd0,
        SD_FETCH = 2'd1,
        SD_LOW   = 2'd2,
        SD_HIGH  = 2'd3
    } sd_state_t;
endpackage

// File: rtl/serdisp_tick.sv
// Half-period timer. While run is high it raises tick on every DIV-th cycle.
// It restarts from zero after each tick, and it holds at zero while run is low.
// Assumes DIV >= 1.
module serdisp_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [W-1:0] cnt;

    assign tick = run && (cnt == W'(DIV - 1));

    // Count the cycles of the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/serdisp_shift.sv
// Byte shifter. load captures a new byte. Each shift moves it one place toward the MSB.
// next_bit is the bit that goes out after the next shift, and last marks the final bit.
// Assumes that load and shift are never high together.
module serdisp_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         next_bit,
    output logic         last
);
    localparam int IW = $clog2(W);

    logic [W-1:0]  shreg;
    logic [IW-1:0] idx;

    assign next_bit = shreg[W-2];
    assign last     = (idx == IW'(W - 1));

    // Hold the byte being sent and count the bits already sent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            idx   <= '0;
        end else if (load) begin
            shreg <= din;
            idx   <= '0;
        end else if (shift) begin
            shreg <= {shreg[W-2:0], 1'b0};
            idx   <= idx + IW'(1);
        end
    end
endmodule

// File: rtl/serdisp_tx.sv
// Four-wire serial display transmitter.
// It sends one command byte (register select 0) or a burst of data bytes
// (register select 1), MSB first. Bytes come from a valid/ready input.
// The serial clock idles high and each half-period lasts CLK_DIV cycles.
// Assumes CLK_DIV >= 1 and BYTE_W >= 2.
module serdisp_tx #(
    parameter int CLK_DIV = 4,
    parameter int BYTE_W  = 8,
    parameter int CNT_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_data,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic [BYTE_W-1:0] din,
    input  logic              din_valid,
    output logic              din_ready,
    output logic              busy,
    output logic              done,
    output logic              dsp_csn,
    output logic              dsp_rs,
    output logic              dsp_sck,
    output logic              dsp_sdo
);
    import serdisp_pkg::*;

    sd_state_t        state;
    logic [CNT_W-1:0] remain;
    logic             csn_q, rs_q, sck_q, sdo_q, done_q;
    logic             tick, next_bit, last_bit;
    logic             phase_run, take_byte, shift_bit;

    assign phase_run = (state == SD_LOW) || (state == SD_HIGH);
    assign take_byte = (state == SD_FETCH) && din_valid;
    assign shift_bit = (state == SD_HIGH) && tick && !last_bit;

    serdisp_tick #(.DIV(CLK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (phase_run),
        .tick (tick)
    );

    serdisp_shift #(.W(BYTE_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (take_byte),
        .shift   (shift_bit),
        .din     (din),
        .next_bit(next_bit),
        .last    (last_bit)
    );

    // Sequence the transfer and drive the four registered lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SD_IDLE;
            remain <= '0;
            csn_q  <= 1'b1;
            rs_q   <= 1'b1;
            sck_q  <= 1'b1;
            sdo_q  <= 1'b1;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                SD_IDLE: begin
                    if (start && (!is_data || byte_count != '0)) begin
                        remain <= is_data ? byte_count : CNT_W'(1);
                        csn_q  <= 1'b0;
                        rs_q   <= is_data;
                        sck_q  <= 1'b0;
                        sdo_q  <= 1'b1;
                        state  <= SD_FETCH;
                    end
                end
                SD_FETCH: begin
                    if (din_valid) begin
                        sdo_q <= din[BYTE_W-1];
                        state <= SD_LOW;
                    end
                end
                SD_LOW: begin
                    if (tick) begin
                        sck_q <= 1'b1;
                        state <= SD_HIGH;
                    end
                end
                SD_HIGH: begin
                    if (tick) begin
                        if (!last_bit) begin
                            sck_q <= 1'b0;
                            sdo_q <= next_bit;
                            state <= SD_LOW;
                        end else if (remain != CNT_W'(1)) begin
                            remain <= remain - CNT_W'(1);
                            sck_q  <= 1'b0;
                            state  <= SD_FETCH;
                        end else begin
                            csn_q  <= 1'b1;
                            rs_q   <= 1'b1;
                            sck_q  <= 1'b1;
                            sdo_q  <= 1'b1;
                            done_q <= 1'b1;
                            state  <= SD_IDLE;
                        end
                    end
                end
                default: state <= SD_IDLE;
            endcase
        end
    end

    assign din_ready = (state == SD_FETCH);
    assign busy      = (state != SD_IDLE);
    assign done      = done_q;
    assign dsp_csn   = csn_q;
    assign dsp_rs    = rs_q;
    assign dsp_sck   = sck_q;
    assign dsp_sdo   = sdo_q;
endmodule

// File: rtl/serdisp_tx_chk.sv
// Protocol checker for serdisp_tx. It watches the ports only and is attached by bind.
module serdisp_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic din_ready,
    input logic dsp_csn,
    input logic dsp_rs,
    input logic dsp_sck,
    input logic dsp_sdo
);
    // R5
    sdo_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dsp_csn && $past(!dsp_csn) && dsp_sck && $past(dsp_sck)) |-> $stable(dsp_sdo));

    // R9
    rs_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dsp_csn && $past(!dsp_csn)) |-> $stable(dsp_rs));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && dsp_csn && dsp_rs && dsp_sck && dsp_sdo));

    // R1
    idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (dsp_csn && dsp_sck && dsp_sdo && dsp_rs && !din_ready));

    // R8
    select_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dsp_csn |-> busy);
endmodule

bind serdisp_tx serdisp_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .din_ready(din_ready),
    .dsp_csn  (dsp_csn),
    .dsp_rs   (dsp_rs),
    .dsp_sck  (dsp_sck),
    .dsp_sdo  (dsp_sdo)
);

// File: tb/serdisp_tx_test.sv
// Directed bench for serdisp_tx. A line monitor rebuilds the bytes and times the clock phases.
module serdisp_tx_test;
    localparam int DIV = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       is_data = 1'b0;
    logic [7:0] byte_count = 8'd0;
    logic [7:0] din = 8'd0;
    logic       din_valid = 1'b0;
    logic       din_ready, busy, done, dsp_csn, dsp_rs, dsp_sck, dsp_sdo;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Monitor state
    logic       p_sck = 1'b1, p_sdo = 1'b1, p_csn = 1'b1;
    logic [7:0] cap = 8'd0;
    int         nbits = 0, rx_n = 0, hi_len = 0, lo_len = 0;
    int         hi_bad = 0, lo_bad = 0, sdo_bad = 0, cs_falls = 0, done_n = 0;
    int         end_bad = 0, busy_seen = 0, ready_seen = 0, line_moves = 0, fed = 0;
    logic [7:0] rx_byte [0:15];
    logic       rx_rs   [0:15];
    logic [7:0] tx      [0:15];

    serdisp_tx #(.CLK_DIV(DIV), .BYTE_W(8), .CNT_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_data(is_data),
        .byte_count(byte_count), .din(din), .din_valid(din_valid),
        .din_ready(din_ready), .busy(busy), .done(done),
        .dsp_csn(dsp_csn), .dsp_rs(dsp_rs), .dsp_sck(dsp_sck), .dsp_sdo(dsp_sdo)
    );

    always #2 clk = ~clk;

    // Watchdog: count cycles and end a hung run as a failure.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d expected <150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Line monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) done_n = done_n + 1;
            if (busy) busy_seen = busy_seen + 1;
            if (din_ready) ready_seen = ready_seen + 1;
            if (!dsp_csn || !dsp_sck || !dsp_sdo || !dsp_rs) line_moves = line_moves + 1;
            if (p_csn && !dsp_csn) cs_falls = cs_falls + 1;
            if (!dsp_csn && !p_csn && dsp_sck && p_sck && dsp_sdo != p_sdo) sdo_bad = sdo_bad + 1;
            if (!p_csn && p_sck && (!dsp_sck || dsp_csn)) begin
                if (hi_len != DIV) hi_bad = hi_bad + 1;
            end
            if (!p_csn && dsp_csn && !(dsp_sck && dsp_sdo && dsp_rs && done)) end_bad = end_bad + 1;
            if (!dsp_csn && dsp_sck && !p_sck) begin
                if (lo_len < DIV) lo_bad = lo_bad + 1;
                lo_len = 0;
                hi_len = 1;
                cap = {cap[6:0], dsp_sdo};
                nbits = nbits + 1;
                if (nbits % 8 == 0 && rx_n < 16) begin
                    rx_byte[rx_n] = cap;
                    rx_rs[rx_n]   = dsp_rs;
                    rx_n = rx_n + 1;
                end
            end else if (!dsp_csn && dsp_sck) begin
                hi_len = hi_len + 1;
            end else if (!dsp_csn && !dsp_sck) begin
                lo_len = lo_len + 1;
            end
            p_sck = dsp_sck;
            p_sdo = dsp_sdo;
            p_csn = dsp_csn;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        nbits = 0; rx_n = 0; hi_bad = 0; lo_bad = 0; sdo_bad = 0; cs_falls = 0;
        done_n = 0; end_bad = 0; busy_seen = 0; ready_seen = 0; line_moves = 0;
        fed = 0; lo_len = 0; hi_len = 0;
    endtask

    task automatic pulse_start(input logic kind, input logic [7:0] cnt);
        @(negedge clk);
        start = 1'b1; is_data = kind; byte_count = cnt;
        @(negedge clk);
        start = 1'b0; is_data = 1'b0; byte_count = 8'd0;
    endtask

    task automatic feed(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            repeat (gap) @(negedge clk);
            din = tx[i];
            din_valid = 1'b1;
            while (!din_ready) @(negedge clk);
            @(negedge clk);
            din_valid = 1'b0;
            din = 8'hxx;
            fed = fed + 1;
        end
    endtask

    task automatic wait_done();
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (done_n > 0) break;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic check_stream(input int n, input logic exp_rs, input string tag);
        chk(rx_n == n, {tag, " byte count"}, rx_n, n);
        for (int i = 0; i < n && i < 16; i++) begin
            chk(rx_byte[i] == tx[i], "R4 MSB-first byte", rx_byte[i], tx[i]);
            chk(rx_rs[i] == exp_rs, {tag, " register select"}, rx_rs[i], exp_rs);
        end
        chk(hi_bad == 0, "R6 high phase length", hi_bad, 0);
        chk(lo_bad == 0, "R6 low phase length", lo_bad, 0);
        chk(sdo_bad == 0, "R5 data change while clock high", sdo_bad, 0);
        chk(cs_falls == 1, "R8 single select window", cs_falls, 1);
        chk(end_bad == 0, "R10 lines high together with done", end_bad, 0);
        chk(done_n == 1, "R10 one done pulse", done_n, 1);
        chk(!busy && dsp_csn && dsp_sck && dsp_sdo && dsp_rs, "R10 idle afterwards",
            {busy, dsp_csn, dsp_sck, dsp_sdo, dsp_rs}, 5'b01111);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(dsp_csn && dsp_rs && dsp_sck && dsp_sdo, "R1 lines in reset",
            {dsp_csn, dsp_rs, dsp_sck, dsp_sdo}, 4'hf);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dsp_csn && dsp_rs && dsp_sck && dsp_sdo, "R1 lines after reset",
            {dsp_csn, dsp_rs, dsp_sck, dsp_sdo}, 4'hf);
        chk(!busy && !done && !din_ready, "R1 status after reset",
            {busy, done, din_ready}, 0);
    endtask

    task automatic t_command();
        clear_mon();
        tx[0] = 8'hA6;
        fork
            pulse_start(1'b0, 8'd5);
            feed(1, 6);
        join
        wait_done();
        chk(fed == 1, "R2 one byte taken", fed, 1);
        check_stream(1, 1'b0, "R2");
    endtask

    task automatic t_data_burst();
        clear_mon();
        tx[0] = 8'h81; tx[1] = 8'h3C; tx[2] = 8'hFF; tx[3] = 8'h00;
        fork
            begin
                pulse_start(1'b1, 8'd4);
                // R7: the start edge has passed, and the first byte is still held back.
                chk(!dsp_csn && !dsp_sck && dsp_sdo && din_ready, "R7 opening levels",
                    {dsp_csn, dsp_sck, dsp_sdo, din_ready}, 4'b0011);
            end
            feed(4, 5);
        join
        wait_done();
        chk(fed == 4, "R3 bytes taken", fed, 4);
        check_stream(4, 1'b1, "R3");
    endtask

    task automatic t_data_single();
        clear_mon();
        tx[0] = 8'h5A;
        fork
            pulse_start(1'b1, 8'd1);
            feed(1, 0);
        join
        wait_done();
        check_stream(1, 1'b1, "R3");
    endtask

    task automatic t_zero_count();
        clear_mon();
        pulse_start(1'b1, 8'd0);
        repeat (40) @(negedge clk);
        chk(busy_seen == 0 && ready_seen == 0, "R11 no activity on zero count",
            busy_seen + ready_seen, 0);
        chk(line_moves == 0 && cs_falls == 0, "R11 lines untouched", line_moves, 0);
    endtask

    task automatic t_start_busy();
        clear_mon();
        tx[0] = 8'hC3; tx[1] = 8'h96;
        fork
            pulse_start(1'b1, 8'd2);
            feed(2, 2);
            begin
                repeat (20) @(negedge clk);
                pulse_start(1'b0, 8'd0);
            end
        join
        wait_done();
        repeat (30) @(negedge clk);
        chk(fed == 2, "R12 bytes taken", fed, 2);
        check_stream(2, 1'b1, "R12");
    endtask

    initial begin
        t_reset();
        t_command();
        t_data_burst();
        t_data_single();
        t_zero_count();
        t_start_busy();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule